// File: doc/BRIEF.md
# SMBus Block-Transfer Master

This block is an SMBus/I2C bus master controlled through a small 16-bit register window. Software writes a transfer length code, a speed choice, the target address with its direction bit, a command byte and up to 32 payload bytes, then sets the start bit. The master then runs one whole command transfer on its own: START, address, command, payload and STOP. For a read it inserts a repeated START and sends the address a second time with the read bit set.

When the transfer ends, a pending flag is set and, if enabled, the interrupt line rises. A busy bit and an acknowledge-error bit can be polled. If the error bit is set while pending is still clear, the transfer is abnormal. Software recovers with a self-clearing soft reset and then waits for busy to drop.

The register port is a plain single-cycle write strobe with a combinational read mux. There is no stream interface and no back-pressure: the host may access any register on any cycle. The bus pins are open-drain and are modelled as pull-low enables. SDA is sampled back from the wired line.

Top module: `smb_block_master`

## Requirements
- R1: After reset, the control word (offset 0x00) and the mode word (offset 0x04) read 0, `irq` is low, and both `scl_oe` and `sda_oe` are low, so both lines are released.
- R2: Mode bits 1:0 set the payload length. Code 00 moves 1 byte, 01 moves 8, 10 moves 16 and 11 moves 32.
- R3: A write sends, in order: START, the address byte with bit 0 forced to 0, the command byte, payload bytes 0..N-1, then STOP. Payload byte 2k is taken from bits 15:8 and byte 2k+1 from bits 7:0 of the buffer word at offset 0x46+2k. SDA only changes while SCL is low, except for START and STOP.
- R4: A read sends START, the address with bit 0 = 0, the command byte, a repeated START, the address with bit 0 = 1, and then receives N bytes. Received byte 2k lands in bits 15:8 and byte 2k+1 in bits 7:0 of buffer word k. Halves that receive no byte keep their contents.
- R5: During a read, the master acknowledges every received byte except the last one, which it NACKs before STOP.
- R6: Control bit 2 (busy) reads 1 from the start request until STOP completes. Both lines are released whenever busy is 0. Setting control bit 0 while busy is 1 starts nothing.
- R7: Control bit 1 (pending) sets when a transfer ends. Writing 1 to it clears it. Control bit 6 enables the interrupt, and `irq` is high exactly when pending and enable are both 1.
- R8: A missing ACK on the address, command or any written byte sets control bit 3 (acknowledge error). The transfer then ends with STOP and sets pending, so there is a window in which the error is 1 while pending is 0. The error bit clears at the next start.
- R9: Writing 1 to control bit 4 aborts any transfer. Within two cycles of the write, busy, pending and the error bit are 0 and both lines are released. Bit 4 always reads 0.
- R10: With mode bit 7 clear, each SCL high time lasts 2·CLK_HZ/(4·STD_HZ) clock cycles. With bit 7 set, it lasts 2·CLK_HZ/(4·FAST_HZ) cycles.
- R11: The address word at 0x02 reads back its low 8 bits. A write anywhere in the command window from 0x06 upward sets the command byte from bits 15:8, and any read in that window returns the byte in both halves.
- R12: The mode word reads back only bits 0, 1, 3, 4 and 7. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Transfer-complete interrupt |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with CLK_HZ = 3.2 MHz. With that clock, the quarter-bit divider is 8 cycles in standard mode and 2 cycles in fast mode. A 32-byte read with its repeated START then takes only about ten thousand cycles, so every length code runs end to end in both directions. The high-time measurements for both speeds come out as small, exact cycle counts.

A behavioural target on the wired lines records the address bytes, START count, command byte, payload order and the master's ACK pattern. It can also refuse a chosen byte, which exercises the acknowledge-error path.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  typedef enum logic [1:0] {EN_IDLE, EN_START, EN_BYTE, EN_STOP} eng_state_t;
  typedef enum logic [1:0] {BK_ADDR, BK_CMD, BK_ADDR2, BK_DATA} byte_kind_t;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_TADR = 8'h02;
  localparam logic [7:0] OFF_MODE = 8'h04;
  localparam logic [7:0] OFF_CMD  = 8'h06;
  localparam logic [7:0] OFF_DATA = 8'h46;

  // Length code to payload byte count.
  function automatic logic [5:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   len_bytes = 6'd1;
      2'b01:   len_bytes = 6'd8;
      2'b10:   len_bytes = 6'd16;
      default: len_bytes = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/smb_clk_tick.sv
`timescale 1ns/1ps
module smb_clk_tick #(
  parameter int QDIV_STD  = 500,
  parameter int QDIV_FAST = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fast,
  output logic tick
);
  localparam int QMAX = (QDIV_STD > QDIV_FAST) ? QDIV_STD : QDIV_FAST;
  localparam int CW   = $clog2(QMAX + 1);
  localparam logic [CW-1:0] LIM_S = CW'(QDIV_STD - 1);
  localparam logic [CW-1:0] LIM_F = CW'(QDIV_FAST - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == (fast ? LIM_F : LIM_S));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/smb_word_buf.sv
`timescale 1ns/1ps
module smb_word_buf #(
  parameter int WORDS = 16,
  localparam int WIW  = $clog2(WORDS),
  localparam int BIW  = WIW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_we,
  input  logic [WIW-1:0] h_idx,
  input  logic [15:0]    h_wdata,
  output logic [15:0]    h_rdata,
  input  logic [BIW-1:0] b_idx,
  input  logic           b_we,
  input  logic [7:0]     b_wdata,
  output logic [7:0]     b_rdata
);
  logic [15:0] mem [WORDS];
  logic [WIW-1:0] b_word;

  assign b_word  = b_idx[BIW-1:1];
  assign h_rdata = mem[h_idx];
  // Even byte index lives in the upper half.
  assign b_rdata = b_idx[0] ? mem[b_word][7:0] : mem[b_word][15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (b_we) begin
      if (b_idx[0]) mem[b_word][7:0]  <= b_wdata;
      else          mem[b_word][15:8] <= b_wdata;
    end else if (h_we) begin
      mem[h_idx] <= h_wdata;
    end
  end
endmodule

// File: rtl/smb_bit_engine.sv
`timescale 1ns/1ps
module smb_bit_engine
  import smb_pkg::*;
#(
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srst,
  input  logic            tick,
  input  logic            go,
  input  logic            rd,
  input  logic [7:0]      adr_byte,
  input  logic [7:0]      cmd,
  input  logic [IDXW:0]   nbytes,
  input  logic [7:0]      tx_byte,
  input  logic            sda_in,
  output logic [IDXW-1:0] bidx,
  output logic            rx_we,
  output logic [7:0]      rx_byte,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            busy,
  output logic            in_byte,
  output logic            done,
  output logic            nack
);
  eng_state_t      st;
  byte_kind_t      kind;
  logic [1:0]      ph;
  logic [3:0]      bitn;
  logic [7:0]      shf;
  logic [IDXW-1:0] idx;
  logic            rs, err_q;
  logic [7:0]      tx_cur;
  logic [2:0]      bsel;
  logic            rx_mode, last_byte, drive_low;

  assign rx_mode   = (kind == BK_DATA) && rd;
  assign last_byte = ({1'b0, idx} == nbytes - 1'b1);
  assign bsel      = 3'd7 - bitn[2:0];
  assign bidx      = idx;
  assign rx_byte   = shf;
  assign busy      = (st != EN_IDLE);
  assign in_byte   = (st == EN_BYTE);
  assign rx_we     = (st == EN_BYTE) && tick && (ph == 2'd3) && bitn[3] && rx_mode && !err_q;

  always_comb begin
    case (kind)
      BK_ADDR:  tx_cur = {adr_byte[7:1], 1'b0};
      BK_CMD:   tx_cur = cmd;
      BK_ADDR2: tx_cur = adr_byte;
      default:  tx_cur = tx_byte;
    endcase
    if (bitn[3]) drive_low = rx_mode && !last_byte;
    else         drive_low = !rx_mode && !tx_cur[bsel];
    case (st)
      EN_START: begin scl_oe = (ph == 2'd0) ? rs : (ph == 2'd3); sda_oe = ph[1]; end
      EN_BYTE:  begin scl_oe = (ph == 2'd0) || (ph == 2'd3);     sda_oe = drive_low; end
      EN_STOP:  begin scl_oe = (ph == 2'd0);                     sda_oe = !ph[1]; end
      default:  begin scl_oe = 1'b0;                             sda_oe = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= EN_IDLE; kind <= BK_ADDR; ph <= '0; bitn <= '0; shf <= '0;
      idx <= '0; rs <= 1'b0; err_q <= 1'b0; done <= 1'b0; nack <= 1'b0;
    end else if (srst) begin
      st <= EN_IDLE; kind <= BK_ADDR; ph <= '0; bitn <= '0;
      idx <= '0; rs <= 1'b0; err_q <= 1'b0; done <= 1'b0; nack <= 1'b0;
    end else begin
      done <= 1'b0;
      nack <= 1'b0;
      if (st == EN_IDLE) begin
        if (go) begin
          st <= EN_START; ph <= '0; rs <= 1'b0; kind <= BK_ADDR;
          idx <= '0; err_q <= 1'b0;
        end
      end else if (tick) begin
        ph <= ph + 1'b1;
        case (st)
          EN_START: if (ph == 2'd3) begin st <= EN_BYTE; bitn <= '0; end
          EN_BYTE: begin
            if (ph == 2'd2) begin
              if (!bitn[3])              shf <= {shf[6:0], sda_in};
              else if (!rx_mode && sda_in) begin err_q <= 1'b1; nack <= 1'b1; end
            end
            if (ph == 2'd3) begin
              if (!bitn[3]) bitn <= bitn + 1'b1;
              else begin
                bitn <= '0;
                if (err_q) st <= EN_STOP;
                else case (kind)
                  BK_ADDR:  kind <= BK_CMD;
                  BK_CMD:   if (rd) begin st <= EN_START; rs <= 1'b1; kind <= BK_ADDR2; end
                            else kind <= BK_DATA;
                  BK_ADDR2: kind <= BK_DATA;
                  default:  if (last_byte) st <= EN_STOP; else idx <= idx + 1'b1;
                endcase
              end
            end
          end
          EN_STOP: if (ph == 2'd3) begin st <= EN_IDLE; done <= 1'b1; end
          default: st <= EN_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_block_master.sv
`timescale 1ns/1ps
module smb_block_master
  import smb_pkg::*;
#(
  parameter int CLK_HZ    = 200_000_000,
  parameter int STD_HZ    = 100_000,
  parameter int FAST_HZ   = 400_000,
  parameter int BUF_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int QDIV_STD  = CLK_HZ / (4 * STD_HZ);
  localparam int QDIV_FAST = CLK_HZ / (4 * FAST_HZ);
  localparam int WIW       = $clog2(BUF_WORDS);
  localparam int BIW       = WIW + 1;
  localparam int WIN_BYTES = 2 * BUF_WORDS;

  logic        ien, pend_q, ackerr_q, srst_q;
  logic [7:0]  tadr, cmd_q;
  logic [1:0]  len_code;
  logic        cap_q, xmode_q, fast_q;
  logic        ctrl_wr, go, in_data, in_cmd, tick;
  logic [7:0]  doff;
  logic [15:0] h_rdata;
  logic [BIW-1:0] bidx;
  logic        rx_we;
  logic [7:0]  rx_byte, tx_byte;
  logic        eng_busy, eng_in_byte, eng_done, eng_nack;

  assign ctrl_wr = reg_wr && (reg_addr == OFF_CTRL);
  assign go      = ctrl_wr && reg_wdata[0] && !eng_busy && !srst_q;
  assign doff    = reg_addr - OFF_DATA;
  assign in_data = (reg_addr >= OFF_DATA) && ({1'b0, reg_addr} < {1'b0, OFF_DATA} + 9'(WIN_BYTES));
  assign in_cmd  = (reg_addr >= OFF_CMD)  && ({1'b0, reg_addr} < {1'b0, OFF_CMD} + 9'(WIN_BYTES));
  assign irq     = pend_q && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= 1'b0; pend_q <= 1'b0; ackerr_q <= 1'b0; srst_q <= 1'b0;
      tadr <= '0; cmd_q <= '0; len_code <= '0;
      cap_q <= 1'b0; xmode_q <= 1'b0; fast_q <= 1'b0;
    end else begin
      srst_q <= ctrl_wr && reg_wdata[4];
      if (ctrl_wr) ien <= reg_wdata[6];
      if (srst_q)                        pend_q <= 1'b0;
      else if (eng_done)                 pend_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[1])  pend_q <= 1'b0;
      if (srst_q || go)                  ackerr_q <= 1'b0;
      else if (eng_nack)                 ackerr_q <= 1'b1;
      if (reg_wr && reg_addr == OFF_TADR) tadr <= reg_wdata[7:0];
      if (reg_wr && reg_addr == OFF_MODE) begin
        len_code <= reg_wdata[1:0]; cap_q <= reg_wdata[3];
        xmode_q  <= reg_wdata[4];   fast_q <= reg_wdata[7];
      end
      if (reg_wr && in_cmd) cmd_q <= reg_wdata[15:8];
    end
  end

  always_comb begin
    if (reg_addr == OFF_CTRL)      reg_rdata = {9'b0, ien, 2'b0, ackerr_q, eng_busy, pend_q, 1'b0};
    else if (reg_addr == OFF_TADR) reg_rdata = {8'b0, tadr};
    else if (reg_addr == OFF_MODE) reg_rdata = {8'b0, fast_q, 2'b0, xmode_q, cap_q, 1'b0, len_code};
    else if (in_cmd)               reg_rdata = {cmd_q, cmd_q};
    else if (in_data)              reg_rdata = h_rdata;
    else                           reg_rdata = '0;
  end

  smb_clk_tick #(.QDIV_STD(QDIV_STD), .QDIV_FAST(QDIV_FAST)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(!eng_busy), .fast(fast_q), .tick(tick)
  );

  smb_word_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .h_we(reg_wr && in_data), .h_idx(doff[WIW:1]), .h_wdata(reg_wdata), .h_rdata(h_rdata),
    .b_idx(bidx), .b_we(rx_we), .b_wdata(rx_byte), .b_rdata(tx_byte)
  );

  smb_bit_engine #(.IDXW(BIW)) u_eng (
    .clk(clk), .rst_n(rst_n), .srst(srst_q), .tick(tick), .go(go),
    .rd(tadr[0]), .adr_byte(tadr), .cmd(cmd_q), .nbytes(len_bytes(len_code)),
    .tx_byte(tx_byte), .sda_in(sda_in), .bidx(bidx), .rx_we(rx_we), .rx_byte(rx_byte),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(eng_busy), .in_byte(eng_in_byte),
    .done(eng_done), .nack(eng_nack)
  );
endmodule

// File: rtl/smb_master_chk.sv
`timescale 1ns/1ps
module smb_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic in_byte,
  input logic scl_oe,
  input logic sda_oe,
  input logic srst,
  input logic done,
  input logic nack,
  input logic ackerr,
  input logic pend,
  input logic irq
);
  assert_lines_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !pend && !ackerr));

  assert_done_sets_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !srst) |=> pend);

  assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  assert_nack_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nack && !srst) |=> ackerr);

  assert_sda_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));
endmodule

bind smb_block_master smb_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .in_byte(eng_in_byte),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .srst(srst_q), .done(eng_done),
  .nack(eng_nack), .ackerr(ackerr_q), .pend(pend_q), .irq(irq)
);

// File: tb/tb_smb_block_master.sv
`timescale 1ns/1ps
module tb_smb_block_master;
  localparam int CLK_HZ = 3_200_000;
  localparam int QS = CLK_HZ / (4 * 100_000);
  localparam int QF = CLK_HZ / (4 * 400_000);
  localparam logic [6:0] TADDR = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic t_oe = 1'b0;
  logic scl_line, sda_line;
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | t_oe);

  always #2.5 clk = ~clk;

  smb_block_master #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  // Behavioural target model on the wired lines.
  logic tgt_rst = 1'b0;
  int   tnack_at = -1;
  logic [7:0] rsrc [64];
  logic [7:0] tmem [64];
  logic       tmack [64];
  int   tph = 0, tbit = 0, tcount = 0, tstarts = 0, trd = 0;
  logic [7:0] tsh = '0, ttx = '0, tcmd = '0, tlast_addr = '0;
  logic trw = 1'b0, tacked = 1'b0, pscl = 1'b1, psda = 1'b1;

  always @(scl_line, sda_line, tgt_rst) begin
    if (tgt_rst) begin
      tph = 0; tbit = 0; tcount = 0; tstarts = 0; trd = 0; t_oe = 1'b0;
    end else if (scl_line && pscl && (sda_line !== psda)) begin
      if (psda && !sda_line) begin tph = 1; tbit = 0; tstarts++; t_oe = 1'b0; end
      else begin tph = 0; t_oe = 1'b0; end
    end else if (scl_line && !pscl && tph != 0) begin
      if (tbit < 8) begin tsh = {tsh[6:0], sda_line}; tbit++; end
      else if (tbit == 8) begin
        if (tph == 4) begin tmack[trd] = ~sda_line; tacked = ~sda_line; end
        tbit = 9;
      end
    end else if (!scl_line && pscl && tph != 0) begin
      if (tbit == 8) begin
        if (tph == 4) t_oe = 1'b0;
        else begin
          tacked = 1'b1;
          case (tph)
            1: begin tacked = (tsh[7:1] == TADDR); trw = tsh[0]; tlast_addr = tsh; end
            2: tcmd = tsh;
            default: begin tmem[tcount] = tsh; tacked = (tcount != tnack_at); tcount++; end
          endcase
          t_oe = tacked;
        end
      end else if (tbit == 9) begin
        t_oe = 1'b0; tbit = 0;
        if (!tacked) tph = 0;
        else case (tph)
          1: if (trw) begin tph = 4; trd = 0; ttx = rsrc[0]; t_oe = ~ttx[7]; end
             else tph = 2;
          2: tph = 3;
          4: begin trd++; ttx = rsrc[trd]; t_oe = ~ttx[7]; end
          default: tph = 3;
        endcase
      end else if (tph == 4 && tbit >= 1 && tbit <= 7) begin
        t_oe = ~ttx[7 - tbit];
      end
    end
    pscl = scl_line; psda = sda_line;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic treset();
    tgt_rst = 1'b1; #1; tgt_rst = 1'b0;
  endtask

  task automatic wait_pend(output logic [15:0] c);
    c = '0;
    for (int i = 0; i < 40000; i++) begin
      rd(8'h00, c);
      if (c[1]) break;
    end
  endtask

  function automatic logic [7:0] pat(input int j);
    return 8'((j * 37 + 11) & 255);
  endfunction

  function automatic int nlen(input logic [1:0] code);
    case (code) 2'b00: return 1; 2'b01: return 8; 2'b10: return 16; default: return 32; endcase
  endfunction

  task automatic test_reset();
    logic [15:0] d;
    rd(8'h00, d); chk(d == 16'h0, "R1 ctrl reset", d, 0);
    rd(8'h04, d); chk(d == 16'h0, "R1 mode reset", d, 0);
    chk(!irq && !scl_oe && !sda_oe, "R1 pins reset", {irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic test_regs();
    logic [15:0] d;
    wr(8'h02, 16'hAB75); rd(8'h02, d); chk(d == 16'h0075, "R11 address readback", d, 16'h0075);
    wr(8'h0A, 16'h5A12); rd(8'h06, d); chk(d == 16'h5A5A, "R11 command replicated", d, 16'h5A5A);
    wr(8'h04, 16'hFFFF); rd(8'h04, d); chk(d == 16'h009B, "R12 mode readback mask", d, 16'h009B);
    wr(8'h04, 16'h0000);
  endtask

  task automatic test_write(input logic [1:0] code, input bit fast);
    logic [15:0] c;
    int n = nlen(code), bad = 0;
    treset();
    for (int k = 0; k < 16; k++) wr(8'(8'h46 + 2 * k), {pat(2 * k), pat(2 * k + 1)});
    wr(8'h04, {8'h0, fast, 2'b0, 1'b1, 2'b0, code});
    wr(8'h02, {8'h0, TADDR, 1'b0});
    wr(8'h06, 16'h5C5C);
    wr(8'h00, 16'h0001);
    wait_pend(c);
    chk(c[1] && !c[3], "R3 write done without error", c, 16'h0002);
    chk(tcount == n, "R2 write byte count", tcount, n);
    for (int j = 0; j < n; j++) if (tmem[j] != pat(j)) bad++;
    chk(bad == 0, "R3 write payload order", bad, 0);
    chk(tcmd == 8'h5C && tstarts == 1 && tlast_addr == {TADDR, 1'b0}, "R3 address and command",
        {tstarts[7:0], tlast_addr, tcmd}, {8'd1, TADDR, 1'b0, 8'h5C});
    wr(8'h00, 16'h0002);
  endtask

  task automatic test_read(input logic [1:0] code);
    logic [15:0] c, w;
    int n = nlen(code), bad = 0, abad = 0;
    treset();
    for (int k = 0; k < 16; k++) wr(8'(8'h46 + 2 * k), 16'h0000);
    wr(8'h04, {14'h0, code});
    wr(8'h02, {8'h0, TADDR, 1'b1});
    wr(8'h00, 16'h0001);
    wait_pend(c);
    chk(c[1] && !c[3], "R4 read done without error", c, 16'h0002);
    for (int j = 0; j < n; j++) begin
      rd(8'(8'h46 + 2 * (j / 2)), w);
      if ((j % 2 == 0 ? w[15:8] : w[7:0]) != rsrc[j]) bad++;
      if (tmack[j] != (j < n - 1)) abad++;
    end
    chk(bad == 0, "R4 read data packing", bad, 0);
    chk(tstarts == 2 && tlast_addr == {TADDR, 1'b1}, "R4 repeated start with read bit",
        {tstarts[7:0], tlast_addr}, {8'd2, TADDR, 1'b1});
    chk(abad == 0 && trd == n - 1, "R5 ack all but last", abad, 0);
    chk(trd + 1 == n, "R2 read byte count", trd + 1, n);
    if (n == 1) begin
      rd(8'h46, w); chk(w[7:0] == 8'h00, "R4 unused half kept", w, {rsrc[0], 8'h00});
    end
    wr(8'h00, 16'h0002);
  endtask

  task automatic test_busy();
    logic [15:0] c;
    treset();
    wr(8'h04, 16'h0000); wr(8'h02, {8'h0, TADDR, 1'b0});
    wr(8'h00, 16'h0001);
    rd(8'h00, c); chk(c[2], "R6 busy after start", c, 16'h0004);
    wr(8'h00, 16'h0001);
    wait_pend(c);
    repeat (200) @(negedge clk);
    rd(8'h00, c);
    chk(!c[2] && tstarts == 1 && tcount == 1, "R6 start while busy ignored",
        {c[2], tstarts[7:0]}, 1);
    chk(!scl_oe && !sda_oe, "R6 lines released when idle", {scl_oe, sda_oe}, 0);
    wr(8'h00, 16'h0002);
  endtask

  task automatic test_irq();
    logic [15:0] c;
    treset();
    wr(8'h00, 16'h0041);
    @(negedge clk); chk(!irq, "R7 irq low while running", irq, 0);
    wait_pend(c);
    @(negedge clk); chk(irq, "R7 irq with pending and enable", irq, 1);
    wr(8'h00, 16'h0042);
    rd(8'h00, c); chk(!c[1] && !irq, "R7 write-one clears pending", {c[1], irq}, 0);
    wr(8'h00, 16'h0001);
    wait_pend(c);
    @(negedge clk); chk(c[1] && !irq, "R7 irq masked when disabled", {c[1], irq}, 2);
    wr(8'h00, 16'h0002);
  endtask

  task automatic test_nack_addr();
    logic [15:0] c;
    bit window = 0;
    treset();
    wr(8'h02, 16'h0022);
    wr(8'h00, 16'h0001);
    for (int i = 0; i < 40000; i++) begin
      rd(8'h00, c);
      if (c[3] && !c[1]) window = 1;
      if (c[1]) break;
    end
    chk(window, "R8 error seen before pending", window, 1);
    chk(c[1] && c[3] && !c[2], "R8 address nack ends transfer", c, 16'h000A);
    chk(tcount == 0, "R8 no payload after nack", tcount, 0);
    wr(8'h00, 16'h0002);
  endtask

  task automatic test_nack_data();
    logic [15:0] c;
    treset();
    tnack_at = 2;
    wr(8'h04, 16'h0001); wr(8'h02, {8'h0, TADDR, 1'b0});
    wr(8'h00, 16'h0001);
    wait_pend(c);
    chk(c[3] && c[1], "R8 data nack flags error", c, 16'h000A);
    chk(tcount == 3, "R8 stop after refused byte", tcount, 3);
    tnack_at = -1;
    wr(8'h00, 16'h0003);
    rd(8'h00, c); chk(!c[3], "R8 error cleared at next start", c[3], 0);
    wait_pend(c);
    wr(8'h00, 16'h0002);
  endtask

  task automatic test_soft_reset();
    logic [15:0] c;
    treset();
    wr(8'h04, 16'h0003); wr(8'h02, {8'h0, TADDR, 1'b0});
    wr(8'h00, 16'h0001);
    repeat (300) @(negedge clk);
    rd(8'h00, c); chk(c[2], "R9 busy before abort", c, 16'h0004);
    wr(8'h00, 16'h0010);
    rd(8'h00, c);
    chk(c == 16'h0000, "R9 abort clears status", c, 0);
    chk(!scl_oe && !sda_oe, "R9 abort releases lines", {scl_oe, sda_oe}, 0);
    treset();
    wr(8'h04, 16'h0000);
    wr(8'h00, 16'h0001);
    wait_pend(c);
    chk(c[1] && !c[3] && tcount == 1, "R9 recovery transfer", c, 16'h0002);
    wr(8'h00, 16'h0002);
  endtask

  task automatic test_rate(input bit fast);
    logic [15:0] c;
    int hi = 0, exp = 2 * (fast ? QF : QS);
    treset();
    wr(8'h04, {8'h0, fast, 7'h0}); wr(8'h02, {8'h0, TADDR, 1'b0});
    wr(8'h00, 16'h0001);
    @(negedge scl_line); @(posedge scl_line);
    while (1) begin
      @(negedge clk);
      if (scl_line) hi++; else break;
    end
    chk(hi == exp, fast ? "R10 fast high time" : "R10 standard high time", hi, exp);
    wait_pend(c);
    wr(8'h00, 16'h0002);
  endtask

  initial begin
    for (int j = 0; j < 64; j++) rsrc[j] = 8'((j * 29 + 7) & 255);
    for (int j = 0; j < 64; j++) begin tmem[j] = '0; tmack[j] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_regs();
    test_write(2'b01, 1'b0);
    test_write(2'b00, 1'b1);
    test_read(2'b11);
    test_read(2'b10);
    test_read(2'b00);
    test_busy();
    test_irq();
    test_nack_addr();
    test_nack_data();
    test_soft_reset();
    test_rate(1'b0);
    test_rate(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule